// File: doc/BRIEF.md
# Filtered Reset Stretcher Sequencer

This block turns an asynchronous, possibly noisy, active-low external reset request into a clean internal reset for a small microcontroller core. The request passes through a synchronizer and then a glitch filter. The filter rejects any low pulse that does not last a minimum number of consecutive clocks. Once a request qualifies, the block raises the internal reset one clock later. The reset then lasts at least a fixed number of clocks, and longer if the external request is still held low when that count expires.

While the internal reset is high, the block produces replacement values for the core's external bus strobes. The data strobe is held low. The address strobe keeps toggling at a programmable half-period, so external logic still sees a running machine rhythm. When the reset ends, the block issues a one-clock load pulse together with a fixed, non-zero start address for the program counter. A separate asynchronous power-on clear puts the block itself into its idle state.

Top module: `rst_filter_seq`

## Requirements
- R1: The filter needs FILT_LEN (default 4) consecutive low samples at the synchronizer output before it accepts a request. A single high sample clears the count. A request low for 3 clocks, or two 3-clock lows split by one high clock, causes no internal reset.
- R2: With the defaults, if `ext_rst_n` is first sampled low at rising edge k and stays low, `int_rst` is high after edge k+6. That is two synchronizer edges and four filter edges, with the assertion falling on the fifth clock after the synchronized low is first seen.
- R3: Once raised, `int_rst` stays high for at least HOLD_LEN (default 18) clocks. A request that is exactly 4 clocks long gives a reset of exactly 18 clocks.
- R4: If the synchronized input is still low when the minimum count ends, `int_rst` stays high until it is seen high. It falls after the third rising edge that samples `ext_rst_n` high. A 40-clock request gives a 36-clock reset.
- R5: A new low request that arrives while the reset is already running does not restart the minimum count. It extends the reset only if the input is still low when the count ends.
- R6: `ds_n_force` is 0 in exactly the cycles where `int_rst` is 1, and 1 otherwise.
- R7: While `int_rst` is high, `as_n_force` starts at 1 in the first reset cycle and inverts every AS_HALF (default 2) clocks, so that in reset cycle i it is 1 when (i / AS_HALF) is even. Outside reset it is 1.
- R8: `pc_load` is high for exactly one clock. That clock is the second cycle after the last high cycle of `int_rst`. `pc_start` always carries START_VEC, which is 0x000C by default.
- R9: While `por_n` is low, `int_rst` and `pc_load` are 0, `as_n_force` and `ds_n_force` are 1, and any count in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear of the block, active low |
| ext_rst_n | input | 1 | Asynchronous external reset request, active low |
| int_rst | output | 1 | Clean internal reset, active high |
| ds_n_force | output | 1 | Data strobe value to drive during reset (low in reset) |
| as_n_force | output | 1 | Address strobe value to drive during reset (toggling in reset) |
| pc_load | output | 1 | One-clock program counter load pulse after reset |
| pc_start | output | VEC_W | Program counter start vector |

## Verification
A filter count that is not cleared shows up as a reset after a broken-up glitch, or as a rise one or more clocks too early, and this is visible within seven clocks of the request. A wrong hold count or a wrong exit decision changes the length of `int_rst`, which is measured against a clock-accurate reference model. A wrong divider phase changes `as_n_force` within the first AS_HALF cycles of reset. A missing or doubled load pulse appears two cycles after the reset ends.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_MIN  = 2'd1,
      RS_EXT  = 2'd2
   } rs_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int   STAGES    = 2,
   parameter logic CLEAR_VAL = 1'b1
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 1) begin : g_bad
         $error("rsq_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge clr_n) begin
               if (!clr_n) sr[0] <= CLEAR_VAL;
               else        sr[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge clr_n) begin
               if (!clr_n) sr[s] <= CLEAR_VAL;
               else        sr[s] <= sr[s-1];
            end
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic clr_n,
   input  logic arm,
   input  logic low_in,
   output logic qual
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

   logic [CW-1:0] run_cnt;
   logic          qual_q;

   generate
      if (FILT_LEN < 1) begin : g_bad
         $error("rsq_filter: FILT_LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         run_cnt <= '0;
         qual_q  <= 1'b0;
      end else begin
         qual_q <= 1'b0;
         if (!arm || qual_q || !low_in) begin
            run_cnt <= '0;
         end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            qual_q  <= 1'b1;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assign qual = qual_q;
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch
   import rst_seq_pkg::*;
#(
   parameter int HOLD_LEN = 18
) (
   input  logic clk,
   input  logic clr_n,
   input  logic qual,
   input  logic low_in,
   output logic arm,
   output logic rst_act,
   output logic load_pulse
);
   localparam int HW = $clog2(HOLD_LEN);
   localparam logic [HW-1:0] LAST = HW'(HOLD_LEN - 1);

   rs_state_e     state;
   logic [HW-1:0] hold_cnt;
   logic          was_act;
   logic          load_q;

   generate
      if (HOLD_LEN < 2) begin : g_bad
         $error("rsq_stretch: HOLD_LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         state    <= RS_IDLE;
         hold_cnt <= '0;
      end else begin
         unique case (state)
            RS_IDLE: begin
               if (qual) begin
                  state    <= RS_MIN;
                  hold_cnt <= '0;
               end
            end
            RS_MIN: begin
               if (hold_cnt == LAST) begin
                  state <= low_in ? RS_EXT : RS_IDLE;
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            RS_EXT: begin
               if (!low_in) state <= RS_IDLE;
            end
            default: state <= RS_IDLE;
         endcase
      end
   end

   assign rst_act = (state != RS_IDLE);
   assign arm     = (state == RS_IDLE);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         was_act <= 1'b0;
         load_q  <= 1'b0;
      end else begin
         was_act <= rst_act;
         load_q  <= was_act & ~rst_act;
      end
   end

   assign load_pulse = load_q;
endmodule

// File: rtl/rsq_strobe.sv
module rsq_strobe #(
   parameter int AS_HALF = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic active,
   output logic as_n
);
   logic as_q;

   generate
      if (AS_HALF < 1) begin : g_bad
         $error("rsq_strobe: AS_HALF must be at least 1");
      end
      if (AS_HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)       as_q <= 1'b1;
            else if (!active) as_q <= 1'b1;
            else              as_q <= ~as_q;
         end
      end else begin : g_div
         localparam int DW = $clog2(AS_HALF);
         localparam logic [DW-1:0] LAST = DW'(AS_HALF - 1);
         logic [DW-1:0] div_cnt;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
               div_cnt <= '0;
               as_q    <= 1'b1;
            end else if (!active) begin
               div_cnt <= '0;
               as_q    <= 1'b1;
            end else if (div_cnt == LAST) begin
               div_cnt <= '0;
               as_q    <= ~as_q;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   endgenerate

   assign as_n = active ? as_q : 1'b1;
endmodule

// File: rtl/rst_filter_seq.sv
module rst_filter_seq #(
   parameter int               SYNC_STAGES = 2,
   parameter int               FILT_LEN    = 4,
   parameter int               HOLD_LEN    = 18,
   parameter int               AS_HALF     = 2,
   parameter int               VEC_W       = 16,
   parameter logic [VEC_W-1:0] START_VEC   = VEC_W'(16'h000C)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ext_rst_n,
   output logic             int_rst,
   output logic             ds_n_force,
   output logic             as_n_force,
   output logic             pc_load,
   output logic [VEC_W-1:0] pc_start
);
   logic sync_n;
   logic arm;
   logic qual;
   logic rst_act;

   generate
      if (VEC_W < 1) begin : g_bad
         $error("rst_filter_seq: VEC_W must be at least 1");
      end
   endgenerate

   rsq_sync #(.STAGES(SYNC_STAGES), .CLEAR_VAL(1'b1)) u_sync (
      .clk(clk), .clr_n(por_n), .d(ext_rst_n), .q(sync_n)
   );

   rsq_filter #(.FILT_LEN(FILT_LEN)) u_filter (
      .clk(clk), .clr_n(por_n), .arm(arm), .low_in(~sync_n), .qual(qual)
   );

   rsq_stretch #(.HOLD_LEN(HOLD_LEN)) u_stretch (
      .clk(clk), .clr_n(por_n), .qual(qual), .low_in(~sync_n),
      .arm(arm), .rst_act(rst_act), .load_pulse(pc_load)
   );

   rsq_strobe #(.AS_HALF(AS_HALF)) u_strobe (
      .clk(clk), .clr_n(por_n), .active(rst_act), .as_n(as_n_force)
   );

   assign int_rst    = rst_act;
   assign ds_n_force = ~rst_act;
   assign pc_start   = START_VEC;
endmodule

// File: rtl/rst_filter_seq_chk.sv
module rst_filter_seq_chk #(
   parameter int HOLD_LEN    = 18,
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic por_n,
   input logic ext_rst_n,
   input logic int_rst,
   input logic as_n_force,
   input logic pc_load
);
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              hi_cnt <= 0;
      else if (!int_rst)       hi_cnt <= 0;
      else if (hi_cnt < 32'hFFFF) hi_cnt <= hi_cnt + 1;
   end

   // R3
   min_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(int_rst) |-> (hi_cnt >= HOLD_LEN));

   // R4
   exit_on_high_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(int_rst) |-> $past(ext_rst_n, SYNC_STAGES + 1));

   // R7
   as_idle_high_chk: assert property (@(posedge clk) disable iff (!por_n)
      !int_rst |-> as_n_force);

   // R8
   load_after_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(int_rst) |=> pc_load);

   // R8
   load_single_chk: assert property (@(posedge clk) disable iff (!por_n)
      pc_load |=> !pc_load);
endmodule

bind rst_filter_seq rst_filter_seq_chk #(.HOLD_LEN(HOLD_LEN), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
   .as_n_force(as_n_force), .pc_load(pc_load)
);

// File: tb/rst_filter_seq_test.sv
module rst_filter_seq_test;
   localparam int FILT = 4;
   localparam int HOLD = 18;
   localparam int ASH  = 2;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        int_rst, ds_n_force, as_n_force, pc_load;
   logic [15:0] pc_start;

   always #2 clk = ~clk;

   rst_filter_seq uut (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
      .ds_n_force(ds_n_force), .as_n_force(as_n_force), .pc_load(pc_load),
      .pc_start(pc_start)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   bit m_p1, m_p2, m_rst, m_pend, m_was, m_pcl;
   int m_run, m_age, m_tot;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_p1 = 1; m_p2 = 1; m_rst = 0; m_pend = 0; m_was = 0; m_pcl = 0;
         m_run = 0; m_age = 0; m_tot = 0;
      end else begin
         bit seen_hi, fire;
         seen_hi = m_p2;
         m_p2 = m_p1;
         m_p1 = ext_rst_n;
         fire = !m_rst && !m_pend && !seen_hi && (m_run == FILT - 1);
         if (m_rst || m_pend || seen_hi || fire) m_run = 0;
         else m_run = m_run + 1;
         m_pcl = m_was && !m_rst;
         m_was = m_rst;
         if (m_pend) begin
            m_rst = 1; m_age = 0; m_tot = 0;
         end else if (m_rst) begin
            m_tot = m_tot + 1;
            if (m_age < HOLD - 1) m_age = m_age + 1;
            else if (seen_hi) m_rst = 0;
         end
         m_pend = fire;
      end
   end

   int hi_total = 0;
   int pcl_total = 0;

   always @(negedge clk) begin
      if (por_n) begin
         bit exp_as;
         exp_as = m_rst ? (((m_tot / ASH) % 2) == 0) : 1'b1;
         chk(int_rst == m_rst, "R2", "int_rst vs model", int_rst, m_rst);
         chk(ds_n_force == !m_rst, "R6", "ds_n_force vs model", ds_n_force, !m_rst);
         chk(as_n_force == exp_as, "R7", "as_n_force vs model", as_n_force, exp_as);
         chk(pc_load == m_pcl, "R8", "pc_load vs model", pc_load, m_pcl);
         if (int_rst) hi_total++;
         if (pc_load) pcl_total++;
      end
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic low_for(input int n);
      ext_rst_n = 1'b0;
      repeat (n) @(negedge clk);
      ext_rst_n = 1'b1;
   endtask

   initial begin
      int h0, p0, lat;
      repeat (3) @(negedge clk);
      // R9: held in power-on clear
      chk(int_rst == 0, "R9", "int_rst in clear", int_rst, 0);
      chk(as_n_force == 1 && ds_n_force == 1, "R9", "strobes in clear",
          {as_n_force, ds_n_force}, 3);
      chk(pc_load == 0, "R9", "pc_load in clear", pc_load, 0);
      por_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: 3-clock glitch
      h0 = hi_total;
      low_for(3);
      repeat (30) @(negedge clk);
      chk(hi_total == h0, "R1", "3-clock glitch reset cycles", hi_total - h0, 0);

      // R1: split low run
      h0 = hi_total;
      low_for(3);
      @(negedge clk);
      low_for(3);
      repeat (30) @(negedge clk);
      chk(hi_total == h0, "R1", "split low run reset cycles", hi_total - h0, 0);

      // R2 R3 R8: 4-clock pulse
      h0 = hi_total; p0 = pcl_total;
      low_for(4);
      repeat (40) @(negedge clk);
      chk(hi_total - h0 == HOLD, "R3", "4-clock pulse reset length", hi_total - h0, HOLD);
      chk(pcl_total - p0 == 1, "R8", "load pulses after reset", pcl_total - p0, 1);
      chk(pc_start == 16'h000C, "R8", "start vector", pc_start, 16'h000C);

      // R2 R4: 40-clock hold
      h0 = hi_total;
      ext_rst_n = 1'b0;
      lat = 0;
      while (!int_rst && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 7, "R2", "assert latency in negedges", lat, 7);
      repeat (40 - lat) @(negedge clk);
      ext_rst_n = 1'b1;
      lat = 0;
      while (int_rst && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 3, "R4", "release latency in negedges", lat, 3);
      repeat (20) @(negedge clk);
      chk(hi_total - h0 == 36, "R4", "40-clock hold reset length", hi_total - h0, 36);

      // R5: second request inside reset, gone before the count ends
      h0 = hi_total;
      low_for(4);
      repeat (12) @(negedge clk);
      chk(int_rst == 1, "R5", "in reset before second request", int_rst, 1);
      low_for(6);
      repeat (40) @(negedge clk);
      chk(hi_total - h0 == HOLD, "R5", "no restart on second request", hi_total - h0, HOLD);

      // R4 R5: second request still low at count end extends
      h0 = hi_total;
      low_for(4);
      repeat (10) @(negedge clk);
      low_for(30);
      repeat (40) @(negedge clk);
      chk(hi_total - h0 == 40, "R4", "late request extends reset", hi_total - h0, 40);

      // R9: clear during reset
      low_for(4);
      repeat (8) @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      chk(int_rst == 0 && pc_load == 0, "R9", "clear aborts reset", {int_rst, pc_load}, 0);
      chk(as_n_force == 1, "R9", "as_n after clear", as_n_force, 1);
      por_n = 1'b1;
      repeat (30) @(negedge clk);
      chk(int_rst == 0, "R9", "no reset after clear", int_rst, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule